// File: doc/BRIEF.md
# Dual Time-Match Alarm Unit

This block watches a running BCD calendar and raises an alarm when the current time agrees with one of two programmed settings. Each setting has six field registers: seconds, minutes, hours, date, month and day of week. Each register pairs a BCD compare value with an enable bit, and only enabled fields are compared. Enabling hours and minutes alone gives an alarm that recurs every day. Also enabling day of week makes it recur every week.

The compare runs only on a one-cycle seconds tick from the timekeeper. A match sets a sticky flag for that setting, and the flag stays set until software clears it over the register bus. A registered, active-low interrupt line can be enabled separately for each setting, so hardware need not poll the status register.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset every alarm field register reads 00h, both flags are 0, the interrupt enables are 0 and irq_n is 1.
- R2: Setting 0 occupies addresses 00h–05h and setting 1 occupies 08h–0Dh, in the field order seconds, minutes, hours, date, month, day of week. Bit 7 of each register is the field enable. The value bits kept are [6:0] for seconds and minutes, [5:0] for hours and date, [4:0] for month and [2:0] for day of week, and all other bits read 0. rd_data holds the addressed value one cycle after rd_en.
- R3: Addresses 07h and 0Fh always read 20h, and writes to them have no effect.
- R4: A setting with no field enable bit set never sets its flag.
- R5: On a tick where every enabled field of a setting equals the current time, that setting's flag is set. Disabled fields are ignored.
- R6: Without a tick, no flag is set, whatever the time inputs show.
- R7: A match that lasts across several ticks sets the flag only on its first tick. A later tick can set the flag again only after a tick without a match.
- R8: Flags stay set until cleared. Status register 11h shows flag 0 at bit 5 and flag 1 at bit 6. Writing 1 to either bit clears that flag.
- R9: Control register 10h holds interrupt enable 0 in bit 0 and interrupt enable 1 in bit 1. irq_n is driven low one cycle after any flag is set while its enable is 1, and is high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per second that enables the compare |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_date | input | 6 | Current date, BCD |
| cur_month | input | 5 | Current month, BCD |
| cur_dow | input | 3 | Current day of week, 0 to 6 |
| bus_addr | input | 5 | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Registered read data |
| alarm_flag | output | 2 | Sticky alarm flags, bit 0 for setting 0 and bit 1 for setting 1 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the unit with its default parameters: a 5-bit address and two alarm settings. With these values every field register, both read-only century addresses, and the control and status registers can be reached by direct bus accesses. One setting is programmed as a weekly alarm and the other as a daily alarm, so a single tick pattern exercises masked fields, day-of-week rejection and re-arming after a match ends. Ticks held back while the time matches, and the interrupt enable toggled around a set flag, cover the gating corners.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int DATA_W   = 8;
  localparam int N_FIELDS = 6;
  localparam int N_ALM    = 2;
  localparam int FLAG_LSB = 5;
  localparam int SEC_W    = 7;
  localparam int MIN_W    = 7;
  localparam int HOUR_W   = 6;
  localparam int DATE_W   = 6;
  localparam int MONTH_W  = 5;
  localparam int DOW_W    = 3;
  localparam logic [2:0] OFF_CENTURY = 3'd7;
  localparam logic [DATA_W-1:0] CENTURY_VAL = 8'h20;

  typedef enum logic [2:0] {
    F_SEC = 3'd0, F_MIN = 3'd1, F_HOUR = 3'd2,
    F_DATE = 3'd3, F_MONTH = 3'd4, F_DOW = 3'd5
  } fld_e;

  // Writable bits of a field register: enable in bit 7 plus the value width.
  function automatic logic [DATA_W-1:0] fld_mask(input int idx);
    int w;
    case (idx)
      0: w = SEC_W;
      1: w = MIN_W;
      2: w = HOUR_W;
      3: w = DATE_W;
      4: w = MONTH_W;
      default: w = DOW_W;
    endcase
    fld_mask = (DATA_W'(1) << (DATA_W - 1)) | ((DATA_W'(1) << w) - DATA_W'(1));
  endfunction
endpackage

// File: rtl/alm_field_regs.sv
module alm_field_regs
  import alm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NF = N_FIELDS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [2:0]      wr_off,
  input  logic [DW-1:0]   wr_data,
  output logic [NF*DW-1:0] regs_flat
);
  for (genvar f = 0; f < NF; f++) begin : g_fld
    localparam logic [DW-1:0] MASK = fld_mask(f);
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst) r <= '0;
      else if (wr_en && wr_off == 3'(f)) r <= wr_data & MASK;
    end
    assign regs_flat[f*DW +: DW] = r;
    assert_mask_R2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((r & ~MASK) == '0));
  end
endmodule

// File: rtl/alm_matcher.sv
module alm_matcher
  import alm_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NF = N_FIELDS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [NF*DW-1:0] regs_flat,
  input  logic [NF*DW-1:0] cur_flat,
  input  logic             clr,
  output logic             flag
);
  logic [NF-1:0] en, eq;
  logic any_en, hit, prev_hit;

  for (genvar f = 0; f < NF; f++) begin : g_cmp
    logic [DW-1:0] val;
    assign en[f]  = regs_flat[f*DW + DW - 1];
    assign val    = regs_flat[f*DW +: DW] & {1'b0, {(DW-1){1'b1}}};
    assign eq[f]  = (val == cur_flat[f*DW +: DW]);
  end

  assign any_en = |en;
  assign hit    = any_en && (&(~en | eq));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_hit <= 1'b0;
      flag     <= 1'b0;
    end else begin
      if (tick) prev_hit <= hit;
      if (tick && hit && !prev_hit) flag <= 1'b1;
      else if (clr)                 flag <= 1'b0;
    end
  end

  assert_no_enable_R4: assert property (@(posedge clk) disable iff (rst)
    (!any_en && !flag) |=> !flag);
  assert_tick_only_R6: assert property (@(posedge clk) disable iff (rst)
    (!tick && !flag) |=> !flag);
  assert_once_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && prev_hit && !flag) |=> !flag);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sec_tick,
  input  logic [SEC_W-1:0]   cur_sec,
  input  logic [MIN_W-1:0]   cur_min,
  input  logic [HOUR_W-1:0]  cur_hour,
  input  logic [DATE_W-1:0]  cur_date,
  input  logic [MONTH_W-1:0] cur_month,
  input  logic [DOW_W-1:0]   cur_dow,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  output logic [N_ALM-1:0]   alarm_flag,
  output logic               irq_n
);
  localparam int RW = N_FIELDS * DATA_W;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(17);

  logic [RW-1:0] cur_flat;
  logic [N_ALM-1:0][RW-1:0] regs_all;
  logic [N_ALM-1:0] irq_en;
  logic [2:0] off;
  logic in_alarm_area;
  logic [DATA_W-1:0] rd_nxt;

  assign cur_flat = {DATA_W'(cur_dow), DATA_W'(cur_month), DATA_W'(cur_date),
                     DATA_W'(cur_hour), DATA_W'(cur_min), DATA_W'(cur_sec)};
  assign off = bus_addr[2:0];
  assign in_alarm_area = (bus_addr >> 4) == '0;

  for (genvar a = 0; a < N_ALM; a++) begin : g_alm
    logic set_wr, clr;
    assign set_wr = wr_en && in_alarm_area && (bus_addr[3] == a[0]) &&
                    (off < 3'(N_FIELDS));
    assign clr    = wr_en && (bus_addr == ADDR_STAT) && wr_data[FLAG_LSB + a];

    alm_field_regs #(.DW(DATA_W), .NF(N_FIELDS)) u_regs (
      .clk(clk), .rst(rst), .wr_en(set_wr), .wr_off(off),
      .wr_data(wr_data), .regs_flat(regs_all[a]));

    alm_matcher #(.DW(DATA_W), .NF(N_FIELDS)) u_match (
      .clk(clk), .rst(rst), .tick(sec_tick), .regs_flat(regs_all[a]),
      .cur_flat(cur_flat), .clr(clr), .flag(alarm_flag[a]));
  end

  always_ff @(posedge clk) begin
    if (rst) irq_en <= '0;
    else if (wr_en && bus_addr == ADDR_CTRL) irq_en <= wr_data[N_ALM-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~|(alarm_flag & irq_en);
  end

  always_comb begin
    rd_nxt = '0;
    if (in_alarm_area) begin
      if (off < 3'(N_FIELDS))    rd_nxt = regs_all[bus_addr[3]][off*DATA_W +: DATA_W];
      else if (off == OFF_CENTURY) rd_nxt = CENTURY_VAL;
    end else if (bus_addr == ADDR_CTRL) begin
      rd_nxt = DATA_W'(irq_en);
    end else if (bus_addr == ADDR_STAT) begin
      rd_nxt = DATA_W'(alarm_flag) << FLAG_LSB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_nxt;
  end

  assert_century_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && in_alarm_area && off == OFF_CENTURY) |=> rd_data == CENTURY_VAL);
  assert_irq_low_R9: assert property (@(posedge clk) disable iff (rst)
    (|(alarm_flag & irq_en)) |=> !irq_n);
  assert_irq_high_R9: assert property (@(posedge clk) disable iff (rst)
    (alarm_flag == '0) |=> irq_n);
endmodule

// File: tb/alarm_match_unit_bench.sv
`timescale 1ns/1ps
module alarm_match_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0;
  logic [6:0] cur_sec = '0, cur_min = '0;
  logic [5:0] cur_hour = '0, cur_date = '0;
  logic [4:0] cur_month = '0;
  logic [2:0] cur_dow = '0;
  logic [4:0] bus_addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] alarm_flag;
  logic irq_n;
  int errors = 0, checks = 0;
  logic [7:0] d;

  always #2.5 clk = ~clk;

  alarm_match_unit u_alarm_match_unit (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .cur_month(cur_month), .cur_dow(cur_dow), .bus_addr(bus_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .alarm_flag(alarm_flag), .irq_n(irq_n));

  // {sec[31:25], min[24:18], hour[17:12], dow[11:9], exp_flag1[1], exp_flag0[0]}
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV] = '{
    {7'h59, 7'h59, 6'h07, 3'd3, 7'b0, 2'b00},
    {7'h00, 7'h00, 6'h08, 3'd3, 7'b0, 2'b01},
    {7'h01, 7'h00, 6'h08, 3'd3, 7'b0, 2'b00},
    {7'h00, 7'h00, 6'h08, 3'd4, 7'b0, 2'b00},
    {7'h00, 7'h30, 6'h21, 3'd4, 7'b0, 2'b10},
    {7'h00, 7'h30, 6'h21, 3'd2, 7'b0, 2'b00},
    {7'h00, 7'h31, 6'h21, 3'd2, 7'b0, 2'b00},
    {7'h00, 7'h30, 6'h21, 3'd5, 7'b0, 2'b10},
    {7'h00, 7'h00, 6'h08, 3'd3, 7'b0, 2'b01}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] v);
    @(negedge clk); bus_addr = a; wr_data = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; rd_en = 1'b1;
    @(negedge clk); v = rd_data; rd_en = 1'b0;
  endtask

  task automatic set_time(input logic [6:0] s, input logic [6:0] m,
                          input logic [5:0] h, input logic [2:0] w);
    cur_sec = s; cur_min = m; cur_hour = h; cur_dow = w;
  endtask

  task automatic tick_at(input logic [6:0] s, input logic [6:0] m,
                         input logic [5:0] h, input logic [2:0] w);
    @(negedge clk); set_time(s, m, h, w); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 flags", {6'b0, alarm_flag}, 8'h00);
    check("R1 irq_n", {7'b0, irq_n}, 8'h01);
    rd(5'h00, d); check("R1 reg 00h", d, 8'h00);
    rd(5'h0D, d); check("R1 reg 0Dh", d, 8'h00);
    rd(5'h10, d); check("R1 ctrl", d, 8'h00);
    // R4: zero time equals zero compare values, yet no enables
    tick_at(7'h00, 7'h00, 6'h00, 3'd0);
    check("R4 disabled alarms", {6'b0, alarm_flag}, 8'h00);
    // R3: century register
    rd(5'h07, d); check("R3 century 07h", d, 8'h20);
    wr(5'h07, 8'h55);
    rd(5'h07, d); check("R3 century after write", d, 8'h20);
    rd(5'h0F, d); check("R3 century 0Fh", d, 8'h20);
    // R2: masking of unused bits
    wr(5'h05, 8'hFF); rd(5'h05, d); check("R2 dow mask", d, 8'h87);
    wr(5'h0A, 8'hFF); rd(5'h0A, d); check("R2 hour mask", d, 8'hBF);
    wr(5'h04, 8'hFF); rd(5'h04, d); check("R2 month mask", d, 8'h9F);
    wr(5'h04, 8'h00);
    // Setting 0: weekly 08:00 on day 3; setting 1: daily 21:30
    wr(5'h01, 8'h80); wr(5'h02, 8'h88); wr(5'h05, 8'h83);
    wr(5'h09, 8'hB0); wr(5'h0A, 8'hA1);
    rd(5'h02, d); check("R2 hour readback", d, 8'h88);
    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      tick_at(v[31:25], v[24:18], v[17:12], v[11:9]);
      check($sformatf("R5/R7 vector %0d", i), {6'b0, alarm_flag}, {6'b0, v[1:0]});
      wr(5'h11, 8'h60);
    end
    // R6: match held without tick
    tick_at(7'h00, 7'h00, 6'h07, 3'd3);
    @(negedge clk); set_time(7'h00, 7'h00, 6'h08, 3'd3);
    repeat (3) @(negedge clk);
    check("R6 no tick", {6'b0, alarm_flag}, 8'h00);
    tick_at(7'h00, 7'h00, 6'h08, 3'd3);
    check("R5 tick sets flag0", {6'b0, alarm_flag}, 8'h01);
    // R8: sticky and clear
    tick_at(7'h00, 7'h00, 6'h09, 3'd3);
    check("R8 sticky", {6'b0, alarm_flag}, 8'h01);
    rd(5'h11, d); check("R8 status bit5", d, 8'h20);
    wr(5'h11, 8'h40);
    check("R8 wrong bit keeps flag", {6'b0, alarm_flag}, 8'h01);
    wr(5'h11, 8'h20);
    check("R8 cleared", {6'b0, alarm_flag}, 8'h00);
    // R9: interrupt gating
    tick_at(7'h00, 7'h00, 6'h08, 3'd3);
    @(negedge clk);
    check("R9 irq gated off", {7'b0, irq_n}, 8'h01);
    wr(5'h10, 8'h01);
    @(negedge clk);
    check("R9 irq asserted", {7'b0, irq_n}, 8'h00);
    wr(5'h11, 8'h20);
    @(negedge clk);
    check("R9 irq released", {7'b0, irq_n}, 8'h01);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule